// File: doc/BRIEF.md
# Word-Systolic Montgomery Multiplier with Speculative Top Bit

The block computes the radix-2 Montgomery product of two operands X and Y with respect to an odd modulus M. The result is S = X·Y·2^-N mod M, left in the non-reduced range [0, 2M). The multiplicand and the modulus are split into E words of W bits each, where E = ceil((N+1)/W). A fixed chain of E processing elements holds one word column of the running sum each. The multiplier bits enter the head element one per cycle, lowest bit first. Each bit then travels down the chain together with its reduction decision.

A word-serial chain normally waits for a neighbour's freshly shifted word before it can start the next bit. Here only the top bit of that word is still unknown when it is needed. Each element therefore forms two candidate sums, one assuming a 0 and one assuming a 1 in that bit. In the following cycle it keeps the candidate that matches the neighbour's now-registered low bit. The array therefore finishes in N+E−1 cycles. One more cycle registers the result.

A host pulses `start` with the three operands on the inputs. It then waits for the one-cycle `done` pulse and reads `result`. The block does no conversion into or out of the Montgomery domain and no final subtraction.

Top module: `mont_spec_mul`

## Requirements
- R1: For odd M with X < M and Y < M, `result` equals the value of the recurrence S←0; for i in 0..N−1: S←S+x_i·Y; if S is odd S←S+M; S←S/2. The value is zero-extended to E·W bits and is below 2M. With X = 0 or Y = 0 it is 0.
- R2: `done` is high for exactly one cycle. It rises N+E clock edges after the edge that accepted `start`: N+E−1 cycles of array work plus one cycle to register the result.
- R3: A `start` pulse that arrives while a product is in progress is ignored. Neither that product's value nor its `done` timing changes.
- R4: After synchronous reset, `done` is 0 and `result` is all zeros.
- R5: `result` changes only on the edge that raises `done`. It then holds its value until the next product completes.
- R6: The operands are sampled only on the accepting edge. Changes to `x_in`, `y_in` or `m_in` afterwards have no effect on the running product.
- R7: A `start` that is high during the cycle in which `done` is high is accepted. Products can therefore run back to back with no idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all state on rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a product; accepted only when idle |
| x_in | input | N | Multiplier operand, scanned bit by bit |
| y_in | input | N | Multiplicand operand, split into words |
| m_in | input | N | Odd modulus |
| done | output | 1 | One-cycle pulse when `result` is updated |
| result | output | E·W | Montgomery product, below 2M |

## Verification
Every product is due exactly N+E edges after its accepting edge. The bench counts falling edges from that edge until it sees `done` and compares the count with N+E. Only in that same half-cycle does it compare `result` against an arithmetic model of the recurrence. Driving the next `start` in the `done` cycle makes back-to-back acceptance part of every run. Operands are scrambled one half-cycle after acceptance. The ignored-start and hold checks sample `result` and `done` at falling edges on either side of the stimulus, so a stray update lands in a checked half-cycle.

// File: rtl/mm_pkg.sv
package mm_pkg;
  typedef logic [1:0] carry_t;

  // number of W-bit words holding an (n+1)-bit value
  function automatic int word_count(int n, int w);
    return (n + w) / w;
  endfunction
endpackage

// File: rtl/mont_pe_head.sv
// Word column 0: derives the reduction bit and speculates on its top bit.
module mont_pe_head #(
  parameter int W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr,
  input  logic               in_valid,
  input  logic               in_x,
  input  logic [W-1:0]       y_w,
  input  logic [W-1:0]       m_w,
  input  logic               nb_lsb,
  output logic               out_valid,
  output logic               out_x,
  output logic               out_q,
  output mm_pkg::carry_t     cout,
  output logic [W-2:0]       hi
);
  localparam int SW = W + 2;
  localparam logic [SW-1:0] TOP_ONE = SW'(1) << (W - 1);

  logic [SW-1:0] cand0, cand1, sel, base;
  logic          q_now;
  logic          unused_lsb;

  // the neighbour's low bit, now registered, resolves the guess
  assign sel        = nb_lsb ? cand1 : cand0;
  assign unused_lsb = sel[0];
  assign q_now      = sel[1] ^ (in_x & y_w[0]);
  assign base       = SW'(sel[W-1:1])
                    + (in_x  ? SW'(y_w) : '0)
                    + (q_now ? SW'(m_w) : '0);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cand0 <= '0;
      cand1 <= '0;
      out_valid <= 1'b0;
      out_x <= 1'b0;
      out_q <= 1'b0;
    end else begin
      out_valid <= in_valid;
      out_x <= in_x;
      out_q <= q_now;
      if (in_valid) begin
        cand0 <= base;
        cand1 <= base + TOP_ONE;
      end else begin
        cand0 <= sel;
        cand1 <= sel;
      end
    end
  end

  assign cout = sel[W+1:W];
  assign hi   = sel[W-1:1];
endmodule

// File: rtl/mont_pe_body.sv
// Middle word column: two candidate sums, resolved one cycle later.
module mont_pe_body #(
  parameter int W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr,
  input  logic               in_valid,
  input  logic               in_x,
  input  logic               in_q,
  input  mm_pkg::carry_t     cin,
  input  logic [W-1:0]       y_w,
  input  logic [W-1:0]       m_w,
  input  logic               nb_lsb,
  output logic               out_valid,
  output logic               out_x,
  output logic               out_q,
  output mm_pkg::carry_t     cout,
  output logic               lsb_out,
  output logic [W-2:0]       hi
);
  localparam int SW = W + 2;
  localparam logic [SW-1:0] TOP_ONE = SW'(1) << (W - 1);

  logic [SW-1:0] cand0, cand1, sel, base;

  assign sel  = nb_lsb ? cand1 : cand0;
  assign base = SW'(sel[W-1:1])
              + (in_x ? SW'(y_w) : '0)
              + (in_q ? SW'(m_w) : '0)
              + SW'(cin);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cand0 <= '0;
      cand1 <= '0;
      out_valid <= 1'b0;
      out_x <= 1'b0;
      out_q <= 1'b0;
    end else begin
      out_valid <= in_valid;
      out_x <= in_x;
      out_q <= in_q;
      if (in_valid) begin
        cand0 <= base;
        cand1 <= base + TOP_ONE;
      end else begin
        cand0 <= sel;
        cand1 <= sel;
      end
    end
  end

  // bit 0 is the same in both candidates
  assign lsb_out = sel[0];
  assign cout    = sel[W+1:W];
  assign hi      = sel[W-1:1];
endmodule

// File: rtl/mont_pe_tail.sv
// Top word column: its pending bit is its own previous carry, so no guess.
module mont_pe_tail #(
  parameter int W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr,
  input  logic               in_valid,
  input  logic               in_x,
  input  logic               in_q,
  input  mm_pkg::carry_t     cin,
  input  logic [W-1:0]       y_w,
  input  logic [W-1:0]       m_w,
  output logic               lsb_out,
  output logic [W-1:0]       top_word
);
  localparam int TW = W + 1;

  logic [TW-1:0] acc, nxt;

  assign nxt = TW'({acc[W], acc[W-1:1]})
             + (in_x ? TW'(y_w) : '0)
             + (in_q ? TW'(m_w) : '0)
             + TW'(cin);

  always_ff @(posedge clk) begin
    if (rst || clr) acc <= '0;
    else if (in_valid) acc <= nxt;
  end

  assign lsb_out  = acc[0];
  assign top_word = acc[W:1];
endmodule

// File: rtl/mont_spec_mul.sv
module mont_spec_mul #(
  parameter int N = 32,
  parameter int W = 8,
  localparam int E  = mm_pkg::word_count(N, W),
  localparam int EW = E * W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [N-1:0]  x_in,
  input  logic [N-1:0]  y_in,
  input  logic [N-1:0]  m_in,
  output logic          done,
  output logic [EW-1:0] result
);
  localparam int CW = $clog2(N + E + 1);
  localparam logic [CW-1:0] RUN_LEN  = CW'(N + E - 1);
  localparam logic [CW-1:0] FEED_MIN = CW'(E);

  logic          busy;
  logic [CW-1:0] cnt;
  logic [N-1:0]  x_sh;
  logic [EW-1:0] y_q, m_q;
  logic          acc, feed;
  logic [EW-1:0] res_w;

  logic           v_a  [0:E-1];
  logic           x_a  [0:E-1];
  logic           q_a  [1:E-1];
  mm_pkg::carry_t cy_a [0:E-2];
  logic           lsb_a[1:E-1];
  logic [W-2:0]   hi_a [0:E-2];
  logic [W-1:0]   top_w;

  assign acc    = start && !busy;
  assign feed   = busy && (cnt >= FEED_MIN);
  assign v_a[0] = feed;
  assign x_a[0] = x_sh[0];

  generate
    for (genvar j = 0; j < E; j++) begin : g_col
      if (j == 0) begin : g_head
        mont_pe_head #(.W(W)) u_pe (
          .clk(clk), .rst(rst), .clr(acc),
          .in_valid(v_a[0]), .in_x(x_a[0]),
          .y_w(y_q[0 +: W]), .m_w(m_q[0 +: W]),
          .nb_lsb(lsb_a[1]),
          .out_valid(v_a[1]), .out_x(x_a[1]), .out_q(q_a[1]),
          .cout(cy_a[0]), .hi(hi_a[0])
        );
      end else if (j == E - 1) begin : g_tail
        mont_pe_tail #(.W(W)) u_pe (
          .clk(clk), .rst(rst), .clr(acc),
          .in_valid(v_a[j]), .in_x(x_a[j]), .in_q(q_a[j]),
          .cin(cy_a[j-1]),
          .y_w(y_q[j*W +: W]), .m_w(m_q[j*W +: W]),
          .lsb_out(lsb_a[j]), .top_word(top_w)
        );
      end else begin : g_body
        mont_pe_body #(.W(W)) u_pe (
          .clk(clk), .rst(rst), .clr(acc),
          .in_valid(v_a[j]), .in_x(x_a[j]), .in_q(q_a[j]),
          .cin(cy_a[j-1]),
          .y_w(y_q[j*W +: W]), .m_w(m_q[j*W +: W]),
          .nb_lsb(lsb_a[j+1]),
          .out_valid(v_a[j+1]), .out_x(x_a[j+1]), .out_q(q_a[j+1]),
          .cout(cy_a[j]), .lsb_out(lsb_a[j]), .hi(hi_a[j])
        );
      end
    end

    // final shift: each word takes its upper neighbour's low bit
    for (genvar j = 0; j < E - 1; j++) begin : g_res
      assign res_w[j*W +: W] = {lsb_a[j+1], hi_a[j]};
    end
  endgenerate
  assign res_w[(E-1)*W +: W] = top_w;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      cnt    <= '0;
      x_sh   <= '0;
      y_q    <= '0;
      m_q    <= '0;
      result <= '0;
    end else begin
      done <= 1'b0;
      if (acc) begin
        busy <= 1'b1;
        cnt  <= RUN_LEN;
        x_sh <= x_in;
        y_q  <= EW'(y_in);
        m_q  <= EW'(m_in);
      end else if (busy) begin
        if (feed) x_sh <= x_sh >> 1;
        if (cnt == '0) begin
          busy   <= 1'b0;
          done   <= 1'b1;
          result <= res_w;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/mont_spec_mul_chk.sv
module mont_spec_mul_chk #(
  parameter int N = 32,
  parameter int W = 8,
  localparam int E  = mm_pkg::word_count(N, W),
  localparam int EW = E * W
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          done,
  input logic [EW-1:0] result,
  input logic          busy,
  input logic [EW-1:0] m_q
);
  logic run_c;
  int   cyc_c;
  logic [EW:0] twice_m;

  assign twice_m = {m_q, 1'b0};

  always_ff @(posedge clk) begin
    if (rst) begin
      run_c <= 1'b0;
      cyc_c <= 0;
    end else if (start && !run_c) begin
      run_c <= 1'b1;
      cyc_c <= 0;
    end else if (run_c) begin
      cyc_c <= cyc_c + 1;
      if (cyc_c == N + E - 1) run_c <= 1'b0;
    end
  end

  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R2
  done_latency_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (cyc_c == N + E));

  // R3
  busy_track_chk: assert property (@(posedge clk) disable iff (rst)
    busy == run_c);

  // R5
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(result) |-> done);

  // R1
  result_range_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> ({1'b0, result} < twice_m));
endmodule

bind mont_spec_mul mont_spec_mul_chk #(.N(N), .W(W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .done(done),
  .result(result), .busy(busy), .m_q(m_q)
);

// File: tb/sim_mont_spec_mul.sv
module sim_mont_spec_mul;
  localparam int N0 = 5;
  localparam int W0 = 2;
  localparam int E0 = mm_pkg::word_count(N0, W0);
  localparam int N1 = 32;
  localparam int W1 = 8;
  localparam int E1 = mm_pkg::word_count(N1, W1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic               a_start = 1'b0;
  logic [N0-1:0]      a_x = '0, a_y = '0, a_m = '0;
  logic               a_done;
  logic [E0*W0-1:0]   a_res;
  logic               b_start = 1'b0;
  logic [N1-1:0]      b_x = '0, b_y = '0, b_m = '0;
  logic               b_done;
  logic [E1*W1-1:0]   b_res;

  mont_spec_mul #(.N(N0), .W(W0)) u0 (
    .clk(clk), .rst(rst), .start(a_start), .x_in(a_x), .y_in(a_y),
    .m_in(a_m), .done(a_done), .result(a_res));

  mont_spec_mul #(.N(N1), .W(W1)) u1 (
    .clk(clk), .rst(rst), .start(b_start), .x_in(b_x), .y_in(b_y),
    .m_in(b_m), .done(b_done), .result(b_res));

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL R2 watchdog actual=%0d expected=<150000", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic logic [63:0] mref(input logic [63:0] x, y, m, input int n);
    logic [63:0] s = '0;
    for (int i = 0; i < n; i++) begin
      if (x[i]) s = s + y;
      if (s[0]) s = s + m;
      s = s >> 1;
    end
    return s;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // called at a falling edge; returns at the falling edge where done is seen
  task automatic run_a(input logic [63:0] x, y, m, output int lat,
                       output logic [63:0] res);
    a_x = x[N0-1:0]; a_y = y[N0-1:0]; a_m = m[N0-1:0];
    a_start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    a_start = 1'b0;
    // R6: scramble operands after acceptance
    a_x = ~a_x; a_y = ~a_y; a_m = ~a_m;
    lat = 0;
    while (a_done !== 1'b1) begin
      @(negedge clk);
      lat++;
    end
    res = 64'(a_res);
  endtask

  task automatic run_b(input logic [63:0] x, y, m, output int lat,
                       output logic [63:0] res);
    b_x = x[N1-1:0]; b_y = y[N1-1:0]; b_m = m[N1-1:0];
    b_start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    b_start = 1'b0;
    b_x = ~b_x; b_y = ~b_y; b_m = ~b_m;
    lat = 0;
    while (b_done !== 1'b1) begin
      @(negedge clk);
      lat++;
    end
    res = 64'(b_res);
  endtask

  initial begin
    int lat;
    logic [63:0] res, exp, held;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R4: reset state
    chk(a_done == 1'b0 && a_res == '0, "R4", 64'(a_res), 0);
    chk(b_done == 1'b0 && b_res == '0, "R4", 64'(b_res), 0);

    // R1 R2 R7: exhaustive over the small array, back-to-back starts
    for (int m = 1; m < 32; m += 2)
      for (int x = 0; x < m; x++)
        for (int y = 0; y < m; y++) begin
          run_a(64'(x), 64'(y), 64'(m), lat, res);
          exp = mref(64'(x), 64'(y), 64'(m), N0);
          chk(res == exp, "R1", res, exp);
          chk(lat == N0 + E0, "R2/R7", 64'(lat), 64'(N0 + E0));
        end

    // R5: result holds while idle and operands wander
    @(negedge clk);
    held = 64'(a_res);
    for (int k = 0; k < 6; k++) begin
      a_x = 5'(k * 7); a_y = 5'(k * 3 + 1); a_m = 5'(k * 5 + 3);
      @(negedge clk);
      chk(a_done == 1'b0 && 64'(a_res) == held, "R5", 64'(a_res), held);
    end

    // R3: second start while busy is ignored
    a_x = 5'd22; a_y = 5'd17; a_m = 5'd29;
    a_start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    a_start = 1'b0;
    lat = 0;
    @(negedge clk); lat++;
    a_x = 5'd3; a_y = 5'd9; a_m = 5'd11; a_start = 1'b1;
    @(negedge clk); lat++;
    a_start = 1'b0;
    chk(a_done == 1'b0, "R3", 64'(a_done), 0);
    while (a_done !== 1'b1) begin
      @(negedge clk);
      lat++;
    end
    exp = mref(64'd22, 64'd17, 64'd29, N0);
    chk(64'(a_res) == exp, "R3", 64'(a_res), exp);
    chk(lat == N0 + E0, "R3", 64'(lat), 64'(N0 + E0));
    @(negedge clk);
    chk(a_done == 1'b0, "R2", 64'(a_done), 0);

    // R1 R2: default-size array, extremes and pseudo-random operands
    for (int k = 0; k < 40; k++) begin
      logic [63:0] m, x, y;
      if (k == 0) begin m = 64'hFFFF_FFFF; x = m - 1; y = m - 1; end
      else if (k == 1) begin m = 64'h8000_0001; x = 0; y = 64'h1234; end
      else if (k == 2) begin m = 64'h8000_0001; x = m - 1; y = 0; end
      else if (k == 3) begin m = 64'd3; x = 2; y = 2; end
      else begin
        m = 64'({$urandom} | 32'h1);
        if (m < 3) m = 64'd5;
        x = 64'($urandom) % m;
        y = 64'($urandom) % m;
      end
      run_b(x, y, m, lat, res);
      exp = mref(x, y, m, N1);
      chk(res == exp, "R1", res, exp);
      chk(lat == N1 + E1, "R2", 64'(lat), 64'(N1 + E1));
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule